// File: doc/BRIEF.md
# Decapsulation Key Stream Router

This block takes a lattice KEM decapsulation key delivered as a byte stream, one byte per clock with an explicit byte address, and places each byte by the address region it falls in. The key is made of four back-to-back regions. The inner secret key goes to a secret-key byte RAM. The embedded encapsulation key goes to a second byte RAM. The 32-byte hash of the encapsulation key and the 32-byte implicit-rejection seed are each captured into a 256-bit register. Every region boundary is computed from a runtime security level K of 2, 3 or 4. With K secret-region units of 384 bytes, the total key length is 768·K + 96 bytes (1632, 2400 or 3168).

A debug port reads back either RAM by index. Downstream stages use the two RAMs and the two wide registers after loading. RAM contents stay in place across operations and across reset until they are written again. Reset clears only the two capture registers.

Top module: `dkey_router`

## Requirements
- R1: Only a security level of 2, 3 or 4 is valid. With any other value on `secLevel`, writes change no RAM byte and neither capture register.
- R2: A write at address a with a < 384·K stores the byte in the secret-key RAM at index a.
- R3: A write at address a with 384·K ≤ a < 768·K + 32 stores the byte in the encapsulation-key RAM at index a − 384·K.
- R4: A write at address a with 768·K + 32 ≤ a < 768·K + 64 stores the byte into `ekHash` as byte j = a − (768·K + 32). Byte j occupies bits 8j+7..8j, and all other bytes keep their value.
- R5: A write at address a with 768·K + 64 ≤ a < 768·K + 96 stores the byte into `rejSeed` as byte j = a − (768·K + 64), with the same bit placement as R4.
- R6: A write at an address of 768·K + 96 or more is ignored. Both capture registers and the RAM byte that a − 384·K would name keep their values.
- R7: The debug read returns a byte one rising edge after `dbgSel`/`dbgIdx` are presented. `dbgSel` = 0 reads the encapsulation-key RAM and `dbgSel` = 1 reads the secret-key RAM. An index beyond the selected RAM's depth returns 0.
- R8: Reset clears `ekHash`, `rejSeed` and `dbgByte` to zero. RAM contents survive reset.
- R9: A byte is accepted on every clock with `wrEn` high, so back-to-back writes to consecutive addresses all land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| secLevel | input | 3 | Security level K (2, 3 or 4) |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 12 | Byte address within the key |
| wrByte | input | 8 | Byte value |
| dbgSel | input | 1 | Debug source: 0 encapsulation-key RAM, 1 secret-key RAM |
| dbgIdx | input | 11 | Debug RAM index |
| dbgByte | output | 8 | Registered debug read data |
| ekHash | output | 256 | Captured encapsulation-key hash, byte j at bits 8j+7..8j |
| rejSeed | output | 256 | Captured implicit-rejection seed, byte j at bits 8j+7..8j |

## Verification
The bench writes the first and last byte of every region at each of the three security levels. A boundary computed with the wrong multiplier, or compared with an off-by-one, then sends an edge byte into the neighbouring destination, and the readback shows the wrong value. Writes just past the end of the key use addresses whose RAM image was preloaded under K = 4. A router that fails to clip the top of the map would overwrite that preloaded byte or disturb the capture registers. An invalid security level, a back-to-back burst, and a mid-run reset are also driven. These catch designs that still decode with a bad K, drop the second of two consecutive bytes, or wipe RAM contents on reset.

// File: rtl/dkr_pkg.sv
package dkr_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 12;
  localparam int IDX_W      = 11;
  localparam int K_W        = 3;
  localparam int K_MIN      = 2;
  localparam int K_MAX      = 4;
  localparam int UNIT_BYTES = 384;
  localparam int SEED_BYTES = 32;
  localparam int SLOT_W     = $clog2(SEED_BYTES);
  localparam int WIDE_W     = SEED_BYTES * BYTE_W;
  localparam int SK_DEPTH   = UNIT_BYTES * K_MAX;
  localparam int EK_DEPTH   = UNIT_BYTES * K_MAX + SEED_BYTES;

  // strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic              skWe;
    logic              ekWe;
    logic              hashWe;
    logic              seedWe;
    logic [IDX_W-1:0]  ramIdx;
    logic [SLOT_W-1:0] slot;
  } dkr_strobe_t;
endpackage

// File: rtl/dkr_ctrl.sv
module dkr_ctrl
  import dkr_pkg::*;
(
  input  logic [K_W-1:0]    secLevel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output dkr_strobe_t       strb
);
  localparam int XW = ADDR_W + 1;

  logic          kValid;
  logic [XW-1:0] skEnd, ekEnd, hashEnd, seedEnd, addrX;
  logic [XW-1:0] ekOff, hashOff, seedOff;
  logic          inSk, inEk, inHash, inSeed;

  always_comb begin
    kValid  = (secLevel >= K_W'(K_MIN)) && (secLevel <= K_W'(K_MAX));
    addrX   = {1'b0, wrAddr};
    skEnd   = XW'(secLevel) * XW'(UNIT_BYTES);
    ekEnd   = (skEnd << 1) + XW'(SEED_BYTES);
    hashEnd = ekEnd + XW'(SEED_BYTES);
    seedEnd = hashEnd + XW'(SEED_BYTES);

    ekOff   = addrX - skEnd;
    hashOff = addrX - ekEnd;
    seedOff = addrX - hashEnd;

    inSk    = addrX < skEnd;
    inEk    = (addrX >= skEnd) && (addrX < ekEnd);
    inHash  = (addrX >= ekEnd) && (addrX < hashEnd);
    inSeed  = (addrX >= hashEnd) && (addrX < seedEnd);

    strb.skWe   = wrEn && kValid && inSk;
    strb.ekWe   = wrEn && kValid && inEk;
    strb.hashWe = wrEn && kValid && inHash;
    strb.seedWe = wrEn && kValid && inSeed;
    strb.ramIdx = inSk ? addrX[IDX_W-1:0] : ekOff[IDX_W-1:0];
    strb.slot   = inHash ? hashOff[SLOT_W-1:0] : seedOff[SLOT_W-1:0];
  end
endmodule

// File: rtl/dkr_datapath.sv
module dkr_datapath
  import dkr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dkr_strobe_t       strb,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              dbgSel,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [BYTE_W-1:0] dbgByte,
  output logic [WIDE_W-1:0] ekHash,
  output logic [WIDE_W-1:0] rejSeed
);
  logic [BYTE_W-1:0] skMem [SK_DEPTH];
  logic [BYTE_W-1:0] ekMem [EK_DEPTH];
  logic [BYTE_W-1:0] hashB [SEED_BYTES];
  logic [BYTE_W-1:0] seedB [SEED_BYTES];
  logic [BYTE_W-1:0] skRd, ekRd;

  // RAM write ports: no reset, contents persist
  always_ff @(posedge clk) begin
    if (strb.skWe) skMem[strb.ramIdx] <= wrByte;
    if (strb.ekWe) ekMem[strb.ramIdx] <= wrByte;
  end

  always_comb begin
    skRd = (dbgIdx < IDX_W'(SK_DEPTH)) ? skMem[dbgIdx] : '0;
    ekRd = (dbgIdx < IDX_W'(EK_DEPTH)) ? ekMem[dbgIdx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dbgByte <= '0;
    else       dbgByte <= dbgSel ? skRd : ekRd;
  end

  // wide capture registers, byte addressed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEED_BYTES; i++) begin
        hashB[i] <= '0;
        seedB[i] <= '0;
      end
    end else begin
      if (strb.hashWe) hashB[strb.slot] <= wrByte;
      if (strb.seedWe) seedB[strb.slot] <= wrByte;
    end
  end

  for (genvar g = 0; g < SEED_BYTES; g++) begin : g_pack
    assign ekHash[BYTE_W*g +: BYTE_W]  = hashB[g];
    assign rejSeed[BYTE_W*g +: BYTE_W] = seedB[g];
  end
endmodule

// File: rtl/dkey_router.sv
module dkey_router
  import dkr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [K_W-1:0]    secLevel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              dbgSel,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [BYTE_W-1:0] dbgByte,
  output logic [WIDE_W-1:0] ekHash,
  output logic [WIDE_W-1:0] rejSeed
);
  dkr_strobe_t strb;

  dkr_ctrl u_ctrl (
    .secLevel (secLevel),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .strb     (strb)
  );

  dkr_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrByte  (wrByte),
    .dbgSel  (dbgSel),
    .dbgIdx  (dbgIdx),
    .dbgByte (dbgByte),
    .ekHash  (ekHash),
    .rejSeed (rejSeed)
  );
endmodule

// File: rtl/dkr_checker.sv
module dkr_checker
  import dkr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [K_W-1:0]    secLevel,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrByte,
  input logic [BYTE_W-1:0] dbgByte,
  input logic [WIDE_W-1:0] ekHash,
  input logic [WIDE_W-1:0] rejSeed
);
  localparam int XW = ADDR_W + 2;
  logic          goodK;
  logic [XW-1:0] a, hashLo, seedLo, keyLen;
  logic          hitHash, hitSeed, beyond, belowHash;
  logic          prevHash, prevSeed;
  logic [SLOT_W-1:0] prevSlot;
  logic [BYTE_W-1:0] prevByte;

  always_comb begin
    goodK     = (secLevel == 3'd2) || (secLevel == 3'd3) || (secLevel == 3'd4);
    a         = XW'(wrAddr);
    keyLen    = XW'(secLevel) * XW'(2 * UNIT_BYTES) + XW'(3 * SEED_BYTES);
    hashLo    = keyLen - XW'(2 * SEED_BYTES);
    seedLo    = keyLen - XW'(SEED_BYTES);
    hitHash   = wrEn && goodK && (a >= hashLo) && (a < seedLo);
    hitSeed   = wrEn && goodK && (a >= seedLo) && (a < keyLen);
    beyond    = wrEn && goodK && (a >= keyLen);
    belowHash = wrEn && goodK && (a < hashLo);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHash <= 1'b0;
      prevSeed <= 1'b0;
      prevSlot <= '0;
      prevByte <= '0;
    end else begin
      prevHash <= hitHash;
      prevSeed <= hitSeed;
      prevSlot <= hitHash ? SLOT_W'(a - hashLo) : SLOT_W'(a - seedLo);
      prevByte <= wrByte;
    end
  end

  // R1
  bad_level_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !goodK) |=> ($stable(ekHash) && $stable(rejSeed)));
  // R4
  hash_byte_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevHash |-> (ekHash[BYTE_W*prevSlot +: BYTE_W] == prevByte));
  // R5
  seed_byte_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevSeed |-> (rejSeed[BYTE_W*prevSlot +: BYTE_W] == prevByte));
  // R6
  past_end_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    beyond |=> ($stable(ekHash) && $stable(rejSeed)));
  // R2
  ram_region_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    belowHash |=> ($stable(ekHash) && $stable(rejSeed)));
  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ekHash == '0 && rejSeed == '0 && dbgByte == '0));
endmodule

bind dkey_router dkr_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .secLevel (secLevel),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrByte   (wrByte),
  .dbgByte  (dbgByte),
  .ekHash   (ekHash),
  .rejSeed  (rejSeed)
);

// File: tb/dkey_router_test.sv
`timescale 1ns/1ps
module dkey_router_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   secLevel = 3'd2;
  logic         wrEn = 1'b0;
  logic [11:0]  wrAddr = '0;
  logic [7:0]   wrByte = '0;
  logic         dbgSel = 1'b0;
  logic [10:0]  dbgIdx = '0;
  logic [7:0]   dbgByte;
  logic [255:0] ekHash, rejSeed;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dkey_router uut (
    .clk(clk), .rstN(rstN), .secLevel(secLevel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrByte(wrByte), .dbgSel(dbgSel), .dbgIdx(dbgIdx),
    .dbgByte(dbgByte), .ekHash(ekHash), .rejSeed(rejSeed)
  );

  // kind: 0 secret RAM, 1 encaps RAM, 2 hash reg, 3 seed reg, 4 ignored
  // for kind 4, idx is the encaps RAM index holding 8'h5A (2047 = none)
  typedef struct packed {
    logic [2:0]  k;
    logic [11:0] addr;
    logic [7:0]  data;
    logic [2:0]  kind;
    logic [10:0] idx;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 12'd2400, 8'h5A, 3'd1, 11'd864},
    '{3'd4, 12'd2784, 8'h5A, 3'd1, 11'd1248},
    '{3'd4, 12'd1535, 8'hA1, 3'd0, 11'd1535},
    '{3'd4, 12'd1536, 8'hA2, 3'd1, 11'd0},
    '{3'd4, 12'd3103, 8'hA3, 3'd1, 11'd1567},
    '{3'd4, 12'd3104, 8'hA4, 3'd2, 11'd0},
    '{3'd4, 12'd3135, 8'hA5, 3'd2, 11'd31},
    '{3'd4, 12'd3136, 8'hA6, 3'd3, 11'd0},
    '{3'd4, 12'd3167, 8'hA7, 3'd3, 11'd31},
    '{3'd4, 12'd3168, 8'hA8, 3'd4, 11'd2047},
    '{3'd2, 12'd0,    8'h11, 3'd0, 11'd0},
    '{3'd2, 12'd767,  8'h12, 3'd0, 11'd767},
    '{3'd2, 12'd768,  8'h13, 3'd1, 11'd0},
    '{3'd2, 12'd1567, 8'h14, 3'd1, 11'd799},
    '{3'd2, 12'd1568, 8'h15, 3'd2, 11'd0},
    '{3'd2, 12'd1599, 8'h16, 3'd2, 11'd31},
    '{3'd2, 12'd1600, 8'h17, 3'd3, 11'd0},
    '{3'd2, 12'd1631, 8'h18, 3'd3, 11'd31},
    '{3'd2, 12'd1632, 8'h19, 3'd4, 11'd864},
    '{3'd3, 12'd1151, 8'h21, 3'd0, 11'd1151},
    '{3'd3, 12'd1152, 8'h22, 3'd1, 11'd0},
    '{3'd3, 12'd2335, 8'h23, 3'd1, 11'd1183},
    '{3'd3, 12'd2336, 8'h24, 3'd2, 11'd0},
    '{3'd3, 12'd2367, 8'h25, 3'd2, 11'd31},
    '{3'd3, 12'd2368, 8'h26, 3'd3, 11'd0},
    '{3'd3, 12'd2400, 8'h28, 3'd4, 11'd1248}
  };

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [2:0] k, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    secLevel = k; wrEn = 1'b1; wrAddr = a; wrByte = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd1(input logic sel, input logic [10:0] i, output logic [7:0] v);
    @(negedge clk);
    dbgSel = sel; dbgIdx = i;
    @(negedge clk);
    v = dbgByte;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]   v;
    logic [255:0] h0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(ekHash == '0, "R8 hash reset", ekHash, '0);
    check(rejSeed == '0, "R8 seed reset", rejSeed, '0);
    check(dbgByte == '0, "R8 dbg reset", dbgByte, '0);

    // table walk: R2 R3 R4 R5 R6 at every level, R7 readback
    for (int n = 0; n < NV; n++) begin
      h0 = ekHash; s0 = rejSeed;
      wr1(VEC[n].k, VEC[n].addr, VEC[n].data);
      case (VEC[n].kind)
        3'd0: begin
          rd1(1'b1, VEC[n].idx, v);
          check(v == VEC[n].data, "R2 R7 secret RAM byte", v, VEC[n].data);
        end
        3'd1: begin
          rd1(1'b0, VEC[n].idx, v);
          check(v == VEC[n].data, "R3 R7 encaps RAM byte", v, VEC[n].data);
        end
        3'd2: check(ekHash[8*VEC[n].idx +: 8] == VEC[n].data, "R4 hash byte",
                    ekHash[8*VEC[n].idx +: 8], VEC[n].data);
        3'd3: check(rejSeed[8*VEC[n].idx +: 8] == VEC[n].data, "R5 seed byte",
                    rejSeed[8*VEC[n].idx +: 8], VEC[n].data);
        default: begin
          check(ekHash == h0 && rejSeed == s0, "R6 capture regs untouched",
                {ekHash ^ h0} | {rejSeed ^ s0}, '0);
          if (VEC[n].idx != 11'd2047) begin
            rd1(1'b0, VEC[n].idx, v);
            check(v == 8'h5A, "R6 RAM byte untouched", v, 8'h5A);
          end
        end
      endcase
    end

    // R1 invalid level: write at address 0 with K=5 must not touch secret RAM 0
    h0 = ekHash; s0 = rejSeed;
    wr1(3'd5, 12'd0, 8'hFF);
    rd1(1'b1, 11'd0, v);
    check(v == 8'h11, "R1 bad level RAM", v, 8'h11);
    wr1(3'd1, 12'd800, 8'hEE);
    check(ekHash == h0 && rejSeed == s0, "R1 bad level capture", ekHash ^ h0, '0);

    // R7 out-of-range index returns zero
    rd1(1'b1, 11'd2000, v);
    check(v == 8'h00, "R7 out of range", v, 8'h00);

    // R9 back-to-back burst into secret RAM and seed register
    @(negedge clk);
    secLevel = 3'd2; wrEn = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wrAddr = 12'(10 + b); wrByte = 8'(8'h30 + b);
      @(negedge clk);
    end
    for (int b = 0; b < 3; b++) begin
      wrAddr = 12'(1610 + b); wrByte = 8'(8'h40 + b);
      @(negedge clk);
    end
    wrEn = 1'b0;
    for (int b = 0; b < 4; b++) begin
      rd1(1'b1, 11'(10 + b), v);
      check(v == 8'(8'h30 + b), "R9 burst secret byte", v, 8'(8'h30 + b));
    end
    check(rejSeed[8*10 +: 24] == 24'h424140, "R9 burst seed bytes",
          rejSeed[8*10 +: 24], 24'h424140);

    // R8 mid-run reset: captures clear, RAM persists
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(ekHash == '0, "R8 hash cleared", ekHash, '0);
    check(rejSeed == '0, "R8 seed cleared", rejSeed, '0);
    rd1(1'b1, 11'd767, v);
    check(v == 8'h12, "R8 secret RAM persists", v, 8'h12);
    rd1(1'b0, 11'd799, v);
    check(v == 8'h14, "R8 encaps RAM persists", v, 8'h14);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule